// File: doc/BRIEF.md
# Buffered Block-Transfer Serial Master

This block is a clock-synchronous serial master that moves a whole block of bytes between a small internal buffer and the serial lines without host help for each byte. The host fills the buffer through a dedicated buffer port and sets the index of the last entry to move. It then writes the start command. The engine reads each entry and shifts it out MSB first while shifting the incoming byte in through the same register. It writes the received byte back into the entry it came from and moves on to the next index.

A transfer ends for one of four reasons: the range is complete, the host asked for a suspend, a bit-shift error was flagged while error checking was enabled, or the host cleared the enable bit. The first three let the byte in progress finish and then raise a one-cycle completion interrupt. Clearing the enable bit stops the engine at once, clears its state and raises no interrupt. A transfer that was cut short cannot be resumed. The host reads the progress counter to learn how many bytes were moved, then sets up a new transfer.

The controller has five states. ST_IDLE goes to ST_LOAD on start. ST_LOAD fetches an entry and always goes to ST_SHIFT. ST_SHIFT runs eight serial clocks and goes to ST_STORE on the last one. ST_STORE writes the entry back, then goes to ST_FINISH if an end cause holds and to ST_LOAD otherwise. ST_FINISH raises the interrupt and goes to ST_IDLE. From any state other than ST_IDLE, a cleared enable bit forces ST_IDLE.

Top module: `autoxfer_serial`

## Requirements
- R1: After reset, the status register (address 3, bit0 busy, bit1 error flag) reads 0, the counter (address 2) reads 0, sck is high and irq is low. sck stays high while no transfer runs.
- R2: Each buffer byte leaves on sdo MSB first, with sdo changing only together with a falling sck. Each byte takes exactly 8 sck cycles, and each sck half lasts HALF clk cycles.
- R3: sdi is sampled at each rising sck, and the assembled byte is written back into the buffer entry that was sent.
- R4: A write to control (address 0) with bit0 (enable) and bit2 (start) both 1 while idle starts a transfer at entry 0 with the counter at 0. The counter rises by one after each byte. After the entry equal to the last-index register (address 1) is moved, the transfer ends with the counter at last+1.
- R5: Writing control bit3 = 1 with bit0 kept at 1 during a transfer lets the byte in progress finish, then ends the transfer.
- R6: A pulse on shift_err sets status bit1. If control bit1 (error check) is 1, the transfer ends after the byte in progress. If it is 0, the transfer runs to the range end. The flag clears at the next start.
- R7: Clearing control bit0 during a transfer returns the block to idle on the next cycle: busy 0, sck high, counter 0, and no irq.
- R8: Every end under R4, R5 or R6 gives exactly one irq pulse lasting one clk cycle, and busy reads 0 afterwards.
- R9: Writes to the last-index register during a transfer are ignored, and the register reads back unchanged.
- R10: A start command written with control bit0 = 0 is ignored: busy stays 0 and no sck edge appears.
- R11: buf_we writes buf_wdata to entry buf_addr, and buf_rdata returns entry buf_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 last index, 2 counter, 3 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| buf_we | input | 1 | Buffer write strobe from the host |
| buf_addr | input | $clog2(DEPTH) | Host buffer index |
| buf_wdata | input | DW | Host buffer write data |
| buf_rdata | output | DW | Buffer entry at buf_addr |
| shift_err | input | 1 | Bit-shift error event |
| sck | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The hardest situations to reach are the early ends, because a suspend or an error must arrive while a chosen byte is still in flight. The bench polls the counter until it shows the target index, waits a few cycles so that the byte is mid-shift, and then issues the suspend write or the error pulse. It then checks that exactly one more byte completed. The same polling places a disable in the middle of a long range, and places a last-index write while busy, so that both land inside a running transfer.

// File: rtl/axs_pkg.sv
package axs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_STORE,
        ST_FINISH
    } axs_state_e;

    localparam logic [1:0] RA_CTRL  = 2'd0;
    localparam logic [1:0] RA_LAST  = 2'd1;
    localparam logic [1:0] RA_COUNT = 2'd2;
    localparam logic [1:0] RA_STAT  = 2'd3;
endpackage

// File: rtl/axs_tick.sv
module axs_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [TW-1:0] cnt;

    assign tick = run && (cnt == TW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/axs_shift.sv
module axs_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_byte,
    input  logic          rise,
    input  logic          fall,
    input  logic          sdi,
    output logic          sdo,
    output logic [DW-1:0] rx_byte
);
    logic [DW-1:0] shreg;
    logic          sdo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            sdo_q <= 1'b1;
        end else if (load) begin
            shreg <= load_byte;
            sdo_q <= load_byte[DW-1];
        end else begin
            if (rise)
                shreg <= {shreg[DW-2:0], sdi};
            if (fall)
                sdo_q <= shreg[DW-1];
        end
    end

    assign sdo     = sdo_q;
    assign rx_byte = shreg;
endmodule

// File: rtl/axs_bufram.sv
module axs_bufram #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr_a,
    output logic [DW-1:0]            rdata_a,
    input  logic [$clog2(DEPTH)-1:0] raddr_b,
    output logic [DW-1:0]            rdata_b
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/autoxfer_serial.sv
module autoxfer_serial
    import axs_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int HALF  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [1:0]               reg_addr,
    input  logic [7:0]               reg_wdata,
    output logic [7:0]               reg_rdata,
    input  logic                     buf_we,
    input  logic [$clog2(DEPTH)-1:0] buf_addr,
    input  logic [DW-1:0]            buf_wdata,
    output logic [DW-1:0]            buf_rdata,
    input  logic                     shift_err,
    output logic                     sck,
    output logic                     sdo,
    input  logic                     sdi,
    output logic                     irq
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam int BW = $clog2(DW);

    axs_state_e     state, nstate;
    logic           en_q, erren_q, susp_q, err_q, phase_hi;
    logic [AW-1:0]  last_q;
    logic [CW-1:0]  count;
    logic [BW-1:0]  bitcnt;
    logic           tick, busy, ctrl_wr, start_req, end_now;
    logic           rise_ev, fall_ev, last_bit, eng_we, load;
    logic [DW-1:0]  fetch_byte, rx_byte, ram_wdata;
    logic [AW-1:0]  ram_waddr;

    assign busy      = (state != ST_IDLE);
    assign ctrl_wr   = reg_we && (reg_addr == RA_CTRL);
    assign start_req = ctrl_wr && reg_wdata[2] && reg_wdata[0] && !busy;
    assign rise_ev   = (state == ST_SHIFT) && tick && !phase_hi;
    assign fall_ev   = (state == ST_SHIFT) && tick && phase_hi && (bitcnt != BW'(DW - 1));
    assign last_bit  = (state == ST_SHIFT) && tick && phase_hi && (bitcnt == BW'(DW - 1));
    assign end_now   = (count[AW-1:0] == last_q) || susp_q || (err_q && erren_q);

    axs_tick #(.HALF(HALF)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(state == ST_SHIFT), .tick(tick)
    );

    axs_shift #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_byte(fetch_byte),
        .rise(rise_ev), .fall(fall_ev), .sdi(sdi), .sdo(sdo), .rx_byte(rx_byte)
    );

    assign ram_waddr = eng_we ? count[AW-1:0] : buf_addr;
    assign ram_wdata = eng_we ? rx_byte : buf_wdata;

    axs_bufram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
        .clk(clk), .we(eng_we || buf_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr_a(buf_addr), .rdata_a(buf_rdata),
        .raddr_b(count[AW-1:0]), .rdata_b(fetch_byte)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nstate;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:   if (start_req) nstate = ST_LOAD;
            ST_LOAD:   nstate = ST_SHIFT;
            ST_SHIFT:  if (last_bit) nstate = ST_STORE;
            ST_STORE:  nstate = end_now ? ST_FINISH : ST_LOAD;
            ST_FINISH: nstate = ST_IDLE;
            default:   nstate = ST_IDLE;
        endcase
        if (busy && !en_q)
            nstate = ST_IDLE;
    end

    // State outputs
    always_comb begin
        sck    = !((state == ST_SHIFT) && !phase_hi);
        irq    = (state == ST_FINISH);
        eng_we = (state == ST_STORE);
        load   = (state == ST_LOAD);
    end

    // Control and progress registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            erren_q  <= 1'b0;
            susp_q   <= 1'b0;
            err_q    <= 1'b0;
            last_q   <= '0;
            count    <= '0;
            phase_hi <= 1'b0;
            bitcnt   <= '0;
        end else begin
            if (ctrl_wr) begin
                en_q    <= reg_wdata[0];
                erren_q <= reg_wdata[1];
                if (reg_wdata[3] && busy)
                    susp_q <= 1'b1;
            end
            if (reg_we && (reg_addr == RA_LAST) && !busy)
                last_q <= reg_wdata[AW-1:0];
            if (shift_err)
                err_q <= 1'b1;
            if (load) begin
                phase_hi <= 1'b0;
                bitcnt   <= '0;
            end
            if (rise_ev)
                phase_hi <= 1'b1;
            if (fall_ev || last_bit)
                phase_hi <= 1'b0;
            if (fall_ev)
                bitcnt <= bitcnt + 1'b1;
            if (state == ST_STORE)
                count <= count + 1'b1;
            if (state == ST_FINISH)
                susp_q <= 1'b0;
            if (start_req) begin
                count  <= '0;
                err_q  <= 1'b0;
                susp_q <= 1'b0;
            end
            if (busy && !en_q) begin
                count    <= '0;
                susp_q   <= 1'b0;
                err_q    <= 1'b0;
                phase_hi <= 1'b0;
            end
        end
    end

    // Register read
    always_comb begin
        unique case (reg_addr)
            RA_CTRL:  reg_rdata = {4'b0, susp_q, 1'b0, erren_q, en_q};
            RA_LAST:  reg_rdata = 8'(last_q);
            RA_COUNT: reg_rdata = 8'(count);
            RA_STAT:  reg_rdata = {6'b0, err_q, busy};
            default:  reg_rdata = 8'h00;
        endcase
    end

    assert_sdo_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(sdo));
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (count == $past(count) || count == $past(count) + CW'(1)));
    assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en_q) |=> (!busy && !irq && sck && count == '0));
    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !busy);
    assert_last_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(last_q));
endmodule

// File: tb/sim_autoxfer_serial.sv
module sim_autoxfer_serial;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;
    localparam int DW    = 8;
    localparam int HALF  = 2;
    localparam int AW    = $clog2(DEPTH);

    // {last, flags(bit0 errchk, bit1 error pulse, bit2 suspend), inject index, expected count}
    localparam logic [31:0] VECS [6] = '{
        {8'd5,  8'h00, 8'd0, 8'd6},
        {8'd0,  8'h00, 8'd0, 8'd1},
        {8'd31, 8'h00, 8'd0, 8'd32},
        {8'd10, 8'h04, 8'd3, 8'd4},
        {8'd10, 8'h03, 8'd2, 8'd3},
        {8'd7,  8'h02, 8'd2, 8'd8}
    };

    logic          clk, rst_n, reg_we, buf_we, shift_err, sck, sdo, sdi, irq;
    logic [1:0]    reg_addr;
    logic [7:0]    reg_wdata, reg_rdata;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] buf_wdata, buf_rdata;

    int checks = 0, errors = 0, irq_cnt = 0, rise_cnt = 0, base = 0, cur_v = 0;
    logic [7:0] cap [DEPTH];

    autoxfer_serial #(.DEPTH(DEPTH), .DW(DW), .HALF(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .shift_err(shift_err), .sck(sck), .sdo(sdo), .sdi(sdi), .irq(irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] sbyte(int i, int v);
        return 8'(i * 29 + v * 7 + 3) ^ 8'h5A;
    endfunction
    function automatic logic [7:0] obyte(int i, int v);
        return 8'(i * 13 + v * 41 + 1);
    endfunction

    // Serial slave model
    always_comb begin
        int r;
        logic [7:0] b;
        r = rise_cnt - base;
        b = sbyte(r / 8, cur_v);
        sdi = b[7 - (r % 8)];
    end
    always @(posedge sck) begin
        int r;
        r = rise_cnt - base;
        if (r >= 0 && r / 8 < DEPTH)
            cap[r / 8][7 - (r % 8)] = sdo;
        rise_cnt = rise_cnt + 1;
    end
    always @(negedge clk) if (irq === 1'b1) irq_cnt = irq_cnt + 1;

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic fill(int v);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            buf_we = 1'b1; buf_addr = AW'(i); buf_wdata = obyte(i, v);
        end
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] d;
        for (int n = 0; n < 6000; n++) begin
            rd(2'd3, d);
            if (!d[0]) break;
        end
    endtask

    task automatic wait_count(int k);
        logic [7:0] d;
        for (int n = 0; n < 6000; n++) begin
            rd(2'd2, d);
            if (d == 8'(k)) break;
        end
    endtask

    task automatic run_vec(int v, logic [31:0] vec);
        logic [7:0] d, ctl;
        int expc, irq0;
        expc = int'(vec[7:0]);
        ctl  = {6'b0, vec[16], 1'b1};
        cur_v = v;
        fill(v);
        wr(2'd1, vec[31:24]);
        base = rise_cnt;
        irq0 = irq_cnt;
        wr(2'd0, ctl | 8'h04);
        if (vec[18:17] != 2'b00) begin
            wait_count(int'(vec[15:8]));
            repeat (3) @(negedge clk);
            if (vec[17]) begin
                shift_err = 1'b1;
                @(negedge clk);
                shift_err = 1'b0;
            end
            if (vec[18]) wr(2'd0, ctl | 8'h08);
        end
        wait_idle();
        rd(2'd2, d);
        chk(vec[18] ? "R5" : (vec[17] ? "R6" : "R4"), "final count", 32'(d), 32'(expc));
        chk("R8", "irq pulses", 32'(irq_cnt - irq0), 32'd1);
        chk("R2", "sck rises", 32'(rise_cnt - base), 32'(8 * expc));
        if (vec[17]) begin
            rd(2'd3, d);
            chk("R6", "error flag", 32'(d[1]), 32'd1);
        end
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            buf_addr = AW'(i);
            #1;
            chk("R3/R11", "buffer entry", 32'(buf_rdata), 32'(i < expc ? sbyte(i, v) : obyte(i, v)));
            if (i < expc) chk("R2", "sent byte", 32'(cap[i]), 32'(obyte(i, v)));
        end
    endtask

    initial begin
        logic [7:0] d;
        int r0, irq0;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        buf_we = 1'b0; buf_addr = '0; buf_wdata = '0; shift_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd3, d); chk("R1", "status after reset", 32'(d), 32'd0);
        rd(2'd2, d); chk("R1", "count after reset", 32'(d), 32'd0);
        chk("R1", "sck idle", 32'(sck), 32'd1);
        chk("R1", "irq idle", 32'(irq), 32'd0);

        for (int v = 0; v < 6; v++) run_vec(v, VECS[v]);
        chk("R1", "sck high after transfer", 32'(sck), 32'd1);

        // R10 start without enable
        r0 = rise_cnt;
        wr(2'd0, 8'h04);
        repeat (20) @(negedge clk);
        rd(2'd3, d);
        chk("R10", "busy after disabled start", 32'(d[0]), 32'd0);
        chk("R10", "sck rises after disabled start", 32'(rise_cnt - r0), 32'd0);

        // R9 last-index write during transfer
        cur_v = 7; fill(7);
        wr(2'd1, 8'd4);
        base = rise_cnt;
        wr(2'd0, 8'h05);
        repeat (5) @(negedge clk);
        wr(2'd1, 8'd20);
        rd(2'd1, d); chk("R9", "last index while busy", 32'(d), 32'd4);
        wait_idle();
        rd(2'd2, d); chk("R9", "count with held range", 32'(d), 32'd5);

        // R7 disable mid-transfer
        wr(2'd1, 8'd20);
        base = rise_cnt;
        wr(2'd0, 8'h05);
        wait_count(3);
        repeat (5) @(negedge clk);
        irq0 = irq_cnt;
        wr(2'd0, 8'h00);
        repeat (2) @(negedge clk);
        rd(2'd3, d); chk("R7", "busy after disable", 32'(d[0]), 32'd0);
        rd(2'd2, d); chk("R7", "count after disable", 32'(d), 32'd0);
        chk("R7", "sck after disable", 32'(sck), 32'd1);
        repeat (100) @(negedge clk);
        chk("R7", "irq after disable", 32'(irq_cnt - irq0), 32'd0);

        summary();
        $finish;
    end
endmodule